// File: doc/BRIEF.md
# Pipelined AES-128 Encryption Round

This block computes a single AES-128 encryption round on a 128-bit state and a 128-bit round key, both supplied in parallel on the same cycle. The round is split across three register stages: byte substitution; row rotation with column mixing; and the key XOR. A new block can enter on every clock. Each block carries its own round key and its own final-round flag through the pipeline, so consecutive blocks may use different keys and round types.

A chip builds a full cipher by chaining or looping instances of this unit and feeding round keys from a separate schedule. Setting the final-round flag on a block skips column mixing for that block only. The byte substitution table is computed in logic from inversion in GF(2^8) followed by the affine map. No stored table is used.

Top module: `aes_round_pipe`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly three clock edges. Every bubble in the input stream appears unchanged in the output stream.
- R2: While `rst_n` is low, and for the first three edges after it goes high with no valid input, `out_vld` is 0.
- R3: Byte i of a block (i = 0..15) occupies bits [127-8i : 120-8i]. Byte i sits at row i mod 4, column i div 4 of the 4x4 state.
- R4: Each state byte x is replaced by S(x) = A(x^-1) ^ 0x63. Here x^-1 is the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapping to 0. A(b) = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4). For example, S(0x00) = 0x63 and S(0x53) = 0xED.
- R5: After substitution, output row r, column c takes the byte from row r, column (c+r) mod 4. Each row therefore rotates left by its row index.
- R6: When `in_last` = 0, each column (a0..a3) becomes m_r = 2·a_r ^ 3·a_(r+1) ^ a_(r+2) ^ a_(r+3), with indices taken mod 4. Multiplication by 2 is a left shift followed by XOR with 0x1B when bit 7 was set.
- R7: The final step XORs the 128-bit round key that entered with the block into the result.
- R8: When `in_last` = 1, column mixing is skipped for that block. Substitution, row rotation and the key XOR still apply.
- R9: Blocks can be accepted on consecutive cycles. Each block's result uses only that block's state, key and final-round flag.
- R10: While `out_vld` is 0, `out_state` holds the most recent valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the valid flags |
| in_vld | input | 1 | Block present on the inputs this cycle |
| in_state | input | 128 | State block, byte 0 in the top bits |
| in_rkey | input | 128 | Round key for this block |
| in_last | input | 1 | Final round: skip column mixing |
| out_state | output | 128 | Round result |
| out_vld | output | 1 | `out_state` holds a new result |

## Verification
All 256 byte values pass through substitution with mixing bypassed. A design with a wrong inversion or affine constant would produce a mismatched byte at one or more values. Single non-zero bytes placed at known rows check the byte order and the rotation direction. A design that rotates the wrong way, or reads bytes in the wrong order, would move 0xED to a different byte lane. A long stream with random gaps, random keys and a final-round flag that toggles per block checks that key and flag stay aligned with their own block. A design that samples these one stage late would mix the wrong block or apply a neighbour's key. Idle stretches after results check that the output holds its value rather than reloading stale pipeline data.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

  localparam int BLK_W  = 128;
  localparam int BYTE_W = 8;
  localparam int N_ROW  = 4;
  localparam int N_BYTE = BLK_W / BYTE_W;
  localparam int N_COL  = N_BYTE / N_ROW;

  localparam logic [7:0] RED_POLY = 8'h1B;
  localparam logic [7:0] AFF_CONST = 8'h63;

  // doubling in GF(2^8)
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? RED_POLY : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_x2(t);
    end
    return acc;
  endfunction

  // a^254 = a^-1 for a != 0, and 0 for a == 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] res;
    sq  = gf_mul(a, a);
    res = sq;
    for (int k = 2; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      res = gf_mul(res, sq);
    end
    return res;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^
           {b[3:0], b[7:4]} ^ AFF_CONST;
  endfunction

  // XOR of all bytes of a block
  function automatic logic [7:0] byte_fold(input logic [BLK_W-1:0] v);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < N_BYTE; i++) acc = acc ^ v[BLK_W-1-BYTE_W*i -: BYTE_W];
    return acc;
  endfunction

  function automatic logic has_zero_byte(input logic [BLK_W-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N_BYTE; i++)
      if (v[BLK_W-1-BYTE_W*i -: BYTE_W] == 8'h00) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/aes_sub_stage.sv
module aes_sub_stage
  import aes_rnd_pkg::*;
#(
  parameter int BW = BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [BW-1:0] dat_i,
  input  logic [BW-1:0] key_i,
  input  logic          last_i,
  output logic          vld_o,
  output logic [BW-1:0] dat_o,
  output logic [BW-1:0] key_o,
  output logic          last_o
);

  localparam int NB = BW / BYTE_W;

  logic          vld_d, vld_q;
  logic [BW-1:0] dat_d, dat_q, key_q;
  logic          last_q;

  for (genvar i = 0; i < NB; i++) begin : g_sbox
    always_comb dat_d[BW-1-BYTE_W*i -: BYTE_W] = sub_byte(dat_i[BW-1-BYTE_W*i -: BYTE_W]);
  end

  always_comb vld_d = vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      dat_q  <= dat_d;
      key_q  <= key_i;
      last_q <= last_i;
    end
  end

  assign vld_o  = vld_q;
  assign dat_o  = dat_q;
  assign key_o  = key_q;
  assign last_o = last_q;

  // R4: the substitution has no fixed point, so no byte survives unchanged
  sbox_no_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> !has_zero_byte(dat_q ^ $past(dat_i)));

endmodule

// File: rtl/aes_mix_stage.sv
module aes_mix_stage
  import aes_rnd_pkg::*;
#(
  parameter int BW = BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [BW-1:0] dat_i,
  input  logic [BW-1:0] key_i,
  input  logic          last_i,
  output logic          vld_o,
  output logic [BW-1:0] dat_o,
  output logic [BW-1:0] key_o
);

  localparam int NB = BW / BYTE_W;
  localparam int NC = NB / N_ROW;

  logic          vld_d, vld_q;
  logic [BW-1:0] shf, dat_d, dat_q, key_q;

  // row r, column c <- row r, column (c+r) mod 4
  for (genvar c = 0; c < NC; c++) begin : g_col
    for (genvar r = 0; r < N_ROW; r++) begin : g_row
      localparam int DST = N_ROW * c + r;
      localparam int SRC = N_ROW * ((c + r) % NC) + r;
      always_comb shf[BW-1-BYTE_W*DST -: BYTE_W] = dat_i[BW-1-BYTE_W*SRC -: BYTE_W];
    end

    logic [7:0] a [N_ROW];
    logic [7:0] m [N_ROW];
    always_comb begin
      for (int r = 0; r < N_ROW; r++) a[r] = shf[BW-1-BYTE_W*(N_ROW*c+r) -: BYTE_W];
      for (int r = 0; r < N_ROW; r++)
        m[r] = gf_x2(a[r]) ^ gf_x2(a[(r+1)%N_ROW]) ^ a[(r+1)%N_ROW] ^
               a[(r+2)%N_ROW] ^ a[(r+3)%N_ROW];
      for (int r = 0; r < N_ROW; r++)
        dat_d[BW-1-BYTE_W*(N_ROW*c+r) -: BYTE_W] = last_i ? a[r] : m[r];
    end
  end

  always_comb vld_d = vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      dat_q <= dat_d;
      key_q <= key_i;
    end
  end

  assign vld_o = vld_q;
  assign dat_o = dat_q;
  assign key_o = key_q;

  // R6: rotation and mixing both keep the XOR of all state bytes
  mix_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (byte_fold(dat_q) == $past(byte_fold(dat_i))));

endmodule

// File: rtl/aes_key_stage.sv
module aes_key_stage
  import aes_rnd_pkg::*;
#(
  parameter int BW = BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [BW-1:0] dat_i,
  input  logic [BW-1:0] key_i,
  output logic          vld_o,
  output logic [BW-1:0] dat_o
);

  logic          vld_d, vld_q;
  logic [BW-1:0] dat_d, dat_q;

  always_comb begin
    vld_d = vld_i;
    dat_d = dat_i ^ key_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (vld_i) dat_q <= dat_d;
  end

  assign vld_o = vld_q;
  assign dat_o = dat_q;

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(dat_q));

endmodule

// File: rtl/aes_round_pipe.sv
module aes_round_pipe
  import aes_rnd_pkg::*;
#(
  parameter int BW = BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [BW-1:0] in_state,
  input  logic [BW-1:0] in_rkey,
  input  logic          in_last,
  output logic [BW-1:0] out_state,
  output logic          out_vld
);

  logic          s1_vld, s1_last, s2_vld;
  logic [BW-1:0] s1_dat, s1_key, s2_dat, s2_key;

  aes_sub_stage #(.BW(BW)) u_sub (
    .clk(clk), .rst_n(rst_n),
    .vld_i(in_vld), .dat_i(in_state), .key_i(in_rkey), .last_i(in_last),
    .vld_o(s1_vld), .dat_o(s1_dat), .key_o(s1_key), .last_o(s1_last)
  );

  aes_mix_stage #(.BW(BW)) u_mix (
    .clk(clk), .rst_n(rst_n),
    .vld_i(s1_vld), .dat_i(s1_dat), .key_i(s1_key), .last_i(s1_last),
    .vld_o(s2_vld), .dat_o(s2_dat), .key_o(s2_key)
  );

  aes_key_stage #(.BW(BW)) u_key (
    .clk(clk), .rst_n(rst_n),
    .vld_i(s2_vld), .dat_i(s2_dat), .key_i(s2_key),
    .vld_o(out_vld), .dat_o(out_state)
  );

  // R1
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 3));

  // R1
  vld_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##3 out_vld);

endmodule

// File: tb/test_aes_round_pipe.sv
module test_aes_round_pipe;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_vld;
  logic [127:0] in_state, in_rkey;
  logic         in_last;
  logic [127:0] out_state;
  logic         out_vld;

  always #2.5 clk = ~clk;

  aes_round_pipe i_aes_round_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_state(in_state),
    .in_rkey(in_rkey), .in_last(in_last), .out_state(out_state), .out_vld(out_vld)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [7:0]  sbt [256];
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] x;
    logic [7:0] p;
    x = {1'b0, a};
    p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x[7:0];
      x = x << 1;
      if (x[8]) x = x ^ 9'h11B;
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_round(input logic [127:0] st, input logic [127:0] k, input logic lst);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] u [16];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) s[i] = sbt[st[127-8*i -: 8]];
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++) t[4*c+w] = s[4*((c+w)%4)+w];
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++)
        u[4*c+w] = lst ? t[4*c+w] :
                   bmul(8'h02, t[4*c+w]) ^ bmul(8'h03, t[4*c+(w+1)%4]) ^
                   t[4*c+(w+2)%4] ^ t[4*c+(w+3)%4];
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = u[i];
    return r ^ k;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic next_rng();
    rng = xs(rng);
  endtask

  // bench pipeline model
  logic [2:0]   vp;
  logic [127:0] dp0, dp1, dp2, last_res;
  bit           have_res = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) vp <= 3'b000;
    else begin
      vp <= {vp[1:0], in_vld};
      if (in_vld) dp0 <= ref_round(in_state, in_rkey, in_last);
      dp1 <= dp0;
      dp2 <= dp1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_vld == vp[2], "R1 out_vld timing", {127'b0, out_vld}, {127'b0, vp[2]});
      if (vp[2]) begin
        chk(out_state == dp2, "R9 stream data", out_state, dp2);
        last_res = dp2;
        have_res = 1'b1;
      end else if (have_res) begin
        chk(out_state == last_res, "R10 hold", out_state, last_res);
      end
    end
  end

  task automatic drive_one(input logic [127:0] st, input logic [127:0] k, input logic lst,
                           output logic [127:0] res);
    @(negedge clk);
    in_vld = 1'b1; in_state = st; in_rkey = k; in_last = lst;
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    res = out_state;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] r0, r1, st, k, e;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, b;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      b = inv;
      sbt[x] = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
    end

    rst_n = 1'b0; in_vld = 1'b0; in_state = '0; in_rkey = '0; in_last = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(out_vld == 1'b0, "R2 in reset", {127'b0, out_vld}, '0);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(out_vld == 1'b0, "R2 after release", {127'b0, out_vld}, '0);
    end

    // R3 R4: byte 0 = 0x53 at the top bits, row 0 does not move
    drive_one({8'h53, 120'h0}, '0, 1'b1, r0);
    e = {8'hED, {15{8'h63}}};
    chk(r0 == e, "R3 R4 byte0 map", r0, e);
    // R5: byte 1 (row 1, col 0) moves to row 1, col 3 = byte 13
    drive_one({8'h00, 8'h53, 112'h0}, '0, 1'b1, r0);
    e = {{13{8'h63}}, 8'hED, 8'h63, 8'h63};
    chk(r0 == e, "R5 row1 rotate", r0, e);
    // R5: byte 3 (row 3, col 0) moves to row 3, col 1 = byte 7
    drive_one({24'h0, 8'h53, 96'h0}, '0, 1'b1, r0);
    e = {{7{8'h63}}, 8'hED, {8{8'h63}}};
    chk(r0 == e, "R5 row3 rotate", r0, e);
    // R10: idle, output unchanged
    repeat (5) @(negedge clk);
    chk(out_state == e && !out_vld, "R10 idle hold", out_state, e);

    // R6 mixing on a patterned state
    st = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    drive_one(st, '0, 1'b0, r0);
    e = ref_round(st, '0, 1'b0);
    chk(r0 == e, "R6 mix", r0, e);
    // R8 same state as final round
    drive_one(st, '0, 1'b1, r1);
    e = ref_round(st, '0, 1'b1);
    chk(r1 == e, "R8 bypass", r1, e);
    // R7 key XOR
    k = 128'hA5A5_0F0F_1234_5678_9ABC_DEF0_0102_0304;
    drive_one(st, k, 1'b0, r1);
    chk((r0 ^ r1) == k, "R7 key xor", r0 ^ r1, k);

    // R4 sweep of every byte value, back to back
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      in_vld = 1'b1; in_state = {16{8'(v)}}; in_rkey = '0; in_last = 1'b1;
    end
    @(negedge clk);
    in_vld = 1'b0;
    repeat (4) @(negedge clk);
    e = {16{sbt[255]}};
    chk(out_state == e, "R4 sweep last", out_state, e);

    // R9 random stream with gaps, per-block key and final flag
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      next_rng();
      in_vld  = rng[0] | rng[1];
      in_last = rng[2];
      next_rng(); in_state[127:96] = rng;
      next_rng(); in_state[95:64]  = rng;
      next_rng(); in_state[63:32]  = rng;
      next_rng(); in_state[31:0]   = rng;
      next_rng(); in_rkey = {rng, ~rng, rng ^ 32'h5A5A5A5A, {rng[15:0], rng[31:16]}};
    end
    @(negedge clk);
    in_vld = 1'b0;
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule